// File: doc/BRIEF.md
# Character LCD 4-bit initialization sequencer

This block runs on the host side of a character display controller. Starting from reset, it brings the controller into 4-bit interface mode and applies a fixed configuration. It drives the register-select line, the read/write line, the enable strobe and a 4-bit data nibble. Every access it makes is an instruction write. It never reads the controller's busy flag, so it spaces all writes by fixed, generous waits. Each wait is derived from a clock-frequency parameter and from delay parameters given in microseconds.

After power is applied and reset is released, the block stays quiet for longer than 15 ms. It then sends the reset nibble 0x3 three times, with a long wait after the first and a shorter wait after the second. Next it sends the single nibble 0x2, which switches the controller to 4-bit mode. Four configuration instructions follow, each split high nibble first. The line-count, font, increment and shift options for these instructions come from static input pins. When the last wait expires, the block raises a completion flag and stays idle until the next reset.

Top module: `lcd4_init_seq`

## Requirements
- R1: While reset is active and after it is released, lcd_e, lcd_rs, lcd_rw and init_done are 0, and no enable pulse starts until more than 15 ms (T_PWR_US, in clock cycles) has passed since the release.
- R2: The first three enable pulses carry nibble 0x3 on lcd_db[3:0]. More than 4.1 ms separates the fall of the first pulse from the rise of the second, and more than 100 us separates the second from the third.
- R3: The fourth pulse carries nibble 0x2, which selects the 4-bit interface.
- R4: Pulses five to twelve carry, in this order: 0x2, {cfg_two_line, cfg_tall_font, 0, 0}, 0x0, 0x8, 0x0, 0x1, 0x0, {0, 1, cfg_incr, cfg_shift}. Bit 3 is the leftmost bit shown.
- R5: lcd_rs and lcd_rw are always 0. Each enable pulse is high for at least 1 us. lcd_db is stable in the cycle before the rise, for the whole high time, and at the fall.
- R6: After the low nibble of the clear instruction (0x1), the gap before the next pulse is at least 2 ms. After the third 0x3, after the lone 0x2 and after every other completed instruction, the gap is at least 50 us.
- R7: init_done rises at least 50 us after the last pulse falls and never before the twelfth pulse. Once high, it stays high and no further enable pulse occurs.
- R8: A reset applied in the middle of the sequence drops lcd_e and init_done at once. The whole sequence, including the power-up wait, then restarts.
- R9: Exactly twelve enable pulses occur between reset release and init_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock whose frequency is the CLK_HZ parameter |
| rst_n | input | 1 | Asynchronous active-low reset, released once power is stable |
| cfg_two_line | input | 1 | Line-count option, sent in bit 3 of the function-set low nibble |
| cfg_tall_font | input | 1 | Font option, sent in bit 2 of the function-set low nibble |
| cfg_incr | input | 1 | Address-increment option, sent in bit 1 of the entry-mode low nibble |
| cfg_shift | input | 1 | Display-shift option, sent in bit 0 of the entry-mode low nibble |
| lcd_rs | output | 1 | Register select, held at 0 (instruction writes only) |
| lcd_rw | output | 1 | Read/write select, held at 0 (writes only) |
| lcd_e | output | 1 | Enable strobe to the display |
| lcd_db | output | 4 | Data nibble to the display |
| init_done | output | 1 | High once the sequence has completed |

## Verification
The bench measures every gap between enable pulses against the minimum for that step. A design that used one common wait everywhere, or that counted from the wrong edge, would violate the long waits after the first reset nibble and after the clear instruction. Each run sets the option pins to different values, so a design that swapped or misplaced the option bits would send a wrong function-set or entry-mode low nibble. A reset applied in the middle of the sequence must restart the power-up wait. A design that kept its step index or its delay counter across that reset would skip ahead or pulse too soon. The bench also watches for pulses after completion and for a completion flag raised before the twelfth pulse.

// File: rtl/lcd4_pkg.sv
`timescale 1ns/1ps
package lcd4_pkg;

   localparam int N_STEPS = 12;

   typedef enum logic [2:0] {
      GAP_NIB,
      GAP_CMD,
      GAP_CLR,
      GAP_RST1,
      GAP_RST2
   } gap_e;

   typedef enum logic [2:0] {
      ST_PWR,
      ST_ISSUE,
      ST_PULSE,
      ST_GAP,
      ST_DONE
   } seq_st_e;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_SETUP,
      PH_HIGH,
      PH_HOLD
   } strobe_ph_e;

   typedef struct packed {
      logic [3:0] nib;
      gap_e       gap;
   } step_t;

   // Convert microseconds to clock cycles, rounding up, never below 1.
   function automatic int cyc_of(input longint hz, input longint us);
      longint r;
      r = (hz * us + 999_999) / 1_000_000;
      if (r < 1) r = 1;
      return int'(r);
   endfunction

   // Nibble and following wait for each step of the start-up sequence.
   function automatic step_t step_at(input logic [3:0] idx, input logic two_line,
                                     input logic tall_font, input logic incr,
                                     input logic shift);
      step_t s;
      s = '{nib: 4'h0, gap: GAP_NIB};
      case (idx)
         4'd0:    s = '{nib: 4'h3, gap: GAP_RST1};
         4'd1:    s = '{nib: 4'h3, gap: GAP_RST2};
         4'd2:    s = '{nib: 4'h3, gap: GAP_CMD};
         4'd3:    s = '{nib: 4'h2, gap: GAP_CMD};
         4'd4:    s = '{nib: 4'h2, gap: GAP_NIB};
         4'd5:    s = '{nib: {two_line, tall_font, 2'b00}, gap: GAP_CMD};
         4'd6:    s = '{nib: 4'h0, gap: GAP_NIB};
         4'd7:    s = '{nib: 4'h8, gap: GAP_CMD};
         4'd8:    s = '{nib: 4'h0, gap: GAP_NIB};
         4'd9:    s = '{nib: 4'h1, gap: GAP_CLR};
         4'd10:   s = '{nib: 4'h0, gap: GAP_NIB};
         4'd11:   s = '{nib: {2'b01, incr, shift}, gap: GAP_CMD};
         default: s = '{nib: 4'h0, gap: GAP_NIB};
      endcase
      return s;
   endfunction

endpackage

// File: rtl/lcd4_delay.sv
`timescale 1ns/1ps
module lcd4_delay #(
   parameter int W    = 20,
   parameter int INIT = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] count,
   output logic         expired
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= W'(INIT);
      end else if (load) begin
         cnt_q <= count;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/lcd4_strobe.sv
`timescale 1ns/1ps
module lcd4_strobe
   import lcd4_pkg::*;
#(
   parameter int SETUP_CYC = 1,
   parameter int EN_CYC    = 1,
   parameter int HOLD_CYC  = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [3:0] nib_in,
   output logic       e_o,
   output logic [3:0] db_o,
   output logic       busy_o
);

   localparam int SW      = $clog2(SETUP_CYC + EN_CYC + HOLD_CYC + 1);
   localparam int HOLD_LD = (HOLD_CYC > 0) ? HOLD_CYC - 1 : 0;

   strobe_ph_e   ph_q;
   strobe_ph_e   after_high;
   logic [SW-1:0] cnt_q;

   initial begin : elab_chk
      if (SETUP_CYC < 1) $error("lcd4_strobe: SETUP_CYC must be at least 1");
      if (EN_CYC < 1)    $error("lcd4_strobe: EN_CYC must be at least 1");
      if (HOLD_CYC < 0)  $error("lcd4_strobe: HOLD_CYC must not be negative");
   end

   generate
      if (HOLD_CYC > 0) begin : g_hold
         assign after_high = PH_HOLD;
      end else begin : g_no_hold
         assign after_high = PH_IDLE;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         cnt_q <= '0;
         e_o   <= 1'b0;
         db_o  <= 4'h0;
      end else begin
         unique case (ph_q)
            PH_IDLE: begin
               if (start) begin
                  db_o  <= nib_in;
                  ph_q  <= PH_SETUP;
                  cnt_q <= SW'(SETUP_CYC - 1);
               end
            end
            PH_SETUP: begin
               if (cnt_q == '0) begin
                  ph_q  <= PH_HIGH;
                  e_o   <= 1'b1;
                  cnt_q <= SW'(EN_CYC - 1);
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            PH_HIGH: begin
               if (cnt_q == '0) begin
                  e_o   <= 1'b0;
                  ph_q  <= after_high;
                  cnt_q <= SW'(HOLD_LD);
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            PH_HOLD: begin
               if (cnt_q == '0) ph_q <= PH_IDLE;
               else             cnt_q <= cnt_q - 1'b1;
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign busy_o = (ph_q != PH_IDLE);

endmodule

// File: rtl/lcd4_init_seq.sv
`timescale 1ns/1ps
module lcd4_init_seq
   import lcd4_pkg::*;
#(
   parameter int CLK_HZ    = 50_000_000,
   parameter int T_PWR_US  = 16_000,
   parameter int T_RST1_US = 4_200,
   parameter int T_RST2_US = 150,
   parameter int T_CMD_US  = 50,
   parameter int T_CLR_US  = 2_000,
   parameter int T_NIB_US  = 1,
   parameter int T_EN_US   = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_two_line,
   input  logic       cfg_tall_font,
   input  logic       cfg_incr,
   input  logic       cfg_shift,
   output logic       lcd_rs,
   output logic       lcd_rw,
   output logic       lcd_e,
   output logic [3:0] lcd_db,
   output logic       init_done
);

   localparam int PWR_CYC   = cyc_of(CLK_HZ, T_PWR_US);
   localparam int RST1_CYC  = cyc_of(CLK_HZ, T_RST1_US);
   localparam int RST2_CYC  = cyc_of(CLK_HZ, T_RST2_US);
   localparam int CMD_CYC   = cyc_of(CLK_HZ, T_CMD_US);
   localparam int CLR_CYC   = cyc_of(CLK_HZ, T_CLR_US);
   localparam int NIB_CYC   = cyc_of(CLK_HZ, T_NIB_US);
   localparam int EN_CYC    = cyc_of(CLK_HZ, T_EN_US);
   localparam int EDGE_CYC  = 1 + CLK_HZ / 10_000_000;
   localparam int DW        = $clog2(PWR_CYC + 1);
   localparam logic [3:0] LAST_IDX = 4'(N_STEPS - 1);

   initial begin : elab_chk
      if (CLK_HZ < 1_000_000) $error("lcd4_init_seq: CLK_HZ below 1 MHz");
      if (T_PWR_US <= 15_000) $error("lcd4_init_seq: power-up wait too short");
      if (T_RST1_US <= 4_100) $error("lcd4_init_seq: first reset wait too short");
      if (T_RST2_US <= 100)   $error("lcd4_init_seq: second reset wait too short");
      if (T_EN_US < 1)        $error("lcd4_init_seq: enable pulse too short");
      if (RST1_CYC > PWR_CYC || CLR_CYC > PWR_CYC || CMD_CYC > PWR_CYC ||
          RST2_CYC > PWR_CYC || NIB_CYC > PWR_CYC)
         $error("lcd4_init_seq: power-up wait must be the longest delay");
   end

   seq_st_e       st_q;
   logic [3:0]    idx_q;
   step_t         cur;
   logic          strb_start;
   logic          strb_busy;
   logic          dly_load;
   logic          dly_zero;
   logic [DW-1:0] gap_cnt;

   assign cur        = step_at(idx_q, cfg_two_line, cfg_tall_font, cfg_incr, cfg_shift);
   assign strb_start = (st_q == ST_ISSUE);
   assign dly_load   = (st_q == ST_PULSE) && !strb_busy;

   always_comb begin
      case (cur.gap)
         GAP_RST1: gap_cnt = DW'(RST1_CYC);
         GAP_RST2: gap_cnt = DW'(RST2_CYC);
         GAP_CMD:  gap_cnt = DW'(CMD_CYC);
         GAP_CLR:  gap_cnt = DW'(CLR_CYC);
         default:  gap_cnt = DW'(NIB_CYC);
      endcase
   end

   lcd4_delay #(
      .W    (DW),
      .INIT (PWR_CYC)
   ) delay_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (dly_load),
      .count   (gap_cnt),
      .expired (dly_zero)
   );

   lcd4_strobe #(
      .SETUP_CYC (EDGE_CYC),
      .EN_CYC    (EN_CYC),
      .HOLD_CYC  (EDGE_CYC)
   ) strobe_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (strb_start),
      .nib_in (cur.nib),
      .e_o    (lcd_e),
      .db_o   (lcd_db),
      .busy_o (strb_busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_PWR;
         idx_q <= 4'd0;
      end else begin
         unique case (st_q)
            ST_PWR:   if (dly_zero) st_q <= ST_ISSUE;
            ST_ISSUE: st_q <= ST_PULSE;
            ST_PULSE: if (!strb_busy) st_q <= ST_GAP;
            ST_GAP: begin
               if (dly_zero) begin
                  if (idx_q == LAST_IDX) begin
                     st_q <= ST_DONE;
                  end else begin
                     idx_q <= idx_q + 4'd1;
                     st_q  <= ST_ISSUE;
                  end
               end
            end
            ST_DONE:  st_q <= ST_DONE;
            default:  st_q <= ST_PWR;
         endcase
      end
   end

   assign lcd_rs    = 1'b0;
   assign lcd_rw    = 1'b0;
   assign init_done = (st_q == ST_DONE);

endmodule

// File: rtl/lcd4_init_seq_chk.sv
`timescale 1ns/1ps
module lcd4_init_seq_chk
   import lcd4_pkg::*;
#(
   parameter int CLK_HZ   = 50_000_000,
   parameter int T_PWR_US = 16_000,
   parameter int T_EN_US  = 1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       lcd_rs,
   input logic       lcd_rw,
   input logic       lcd_e,
   input logic [3:0] lcd_db,
   input logic       init_done
);

   localparam int PWR_CYC = cyc_of(CLK_HZ, T_PWR_US);
   localparam int EN_CYC  = cyc_of(CLK_HZ, T_EN_US);

   int since_rst;
   int hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_rst <= 0;
         hi_cnt    <= 0;
      end else begin
         if (since_rst < PWR_CYC) since_rst <= since_rst + 1;
         hi_cnt <= lcd_e ? hi_cnt + 1 : 0;
      end
   end

   p_quiet_power_r1: assert property (@(posedge clk) disable iff (!rst_n)
      lcd_e |-> since_rst >= PWR_CYC);

   p_write_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !lcd_rs && !lcd_rw);

   p_db_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lcd_e) |-> $stable(lcd_db));

   p_db_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
      lcd_e && $past(lcd_e) |-> $stable(lcd_db));

   p_db_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lcd_e) |-> $stable(lcd_db));

   p_pulse_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lcd_e) |-> hi_cnt >= EN_CYC);

   p_done_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);

   p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |-> !lcd_e);

endmodule

bind lcd4_init_seq lcd4_init_seq_chk #(
   .CLK_HZ   (CLK_HZ),
   .T_PWR_US (T_PWR_US),
   .T_EN_US  (T_EN_US)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .lcd_rs    (lcd_rs),
   .lcd_rw    (lcd_rw),
   .lcd_e     (lcd_e),
   .lcd_db    (lcd_db),
   .init_done (init_done)
);

// File: tb/lcd4_init_seq_tb_top.sv
`timescale 1ns/1ps
module lcd4_init_seq_tb_top;

   // Timing is scaled: one clock cycle stands for 1 us (CLK_HZ = 1 MHz).
   localparam int CLK_HZ = 1_000_000;

   // {kind, nibble, minimum gap in cycles to the next rise}
   // kind 0: fixed nibble, 1: {N,F,0,0}, 2: {0,1,I/D,S}
   localparam logic [21:0] VEC [12] = '{
      {2'd0, 4'h3, 16'd4101},
      {2'd0, 4'h3, 16'd101},
      {2'd0, 4'h3, 16'd50},
      {2'd0, 4'h2, 16'd50},
      {2'd0, 4'h2, 16'd1},
      {2'd1, 4'h0, 16'd50},
      {2'd0, 4'h0, 16'd1},
      {2'd0, 4'h8, 16'd50},
      {2'd0, 4'h0, 16'd1},
      {2'd0, 4'h1, 16'd2000},
      {2'd0, 4'h0, 16'd1},
      {2'd2, 4'h0, 16'd0}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_two_line = 1'b0, cfg_tall_font = 1'b0, cfg_incr = 1'b0, cfg_shift = 1'b0;
   logic       lcd_rs, lcd_rw, lcd_e, init_done;
   logic [3:0] lcd_db;

   int  n_chk = 0;
   int  n_err = 0;
   bit  finished = 0;

   always #10 clk = ~clk;

   lcd4_init_seq #(.CLK_HZ(CLK_HZ)) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_two_line  (cfg_two_line),
      .cfg_tall_font (cfg_tall_font),
      .cfg_incr      (cfg_incr),
      .cfg_shift     (cfg_shift),
      .lcd_rs        (lcd_rs),
      .lcd_rw        (lcd_rw),
      .lcd_e         (lcd_e),
      .lcd_db        (lcd_db),
      .init_done     (init_done)
   );

   // Pulse monitor, sampling at the falling clock edge.
   bit         mon_clr = 1;
   longint     ncyc = 0, rel_c = 0, done_c = -1;
   longint     rise_c [16];
   longint     fall_c [16];
   logic [3:0] nib_c [16];
   int         np = 0, stab_err = 0, rsrw_err = 0, late_pulse = 0, early_done = 0;
   logic       e_q = 0, rst_q = 0, done_q = 0;
   logic [3:0] db_q = 0;

   always @(negedge clk) begin
      ncyc++;
      if (mon_clr) begin
         np = 0; stab_err = 0; rsrw_err = 0; late_pulse = 0; early_done = 0;
         done_c = -1;
      end else begin
         if (rst_n && !rst_q) rel_c = ncyc;
         if (lcd_e && !e_q) begin
            if (np < 16) begin rise_c[np] = ncyc; nib_c[np] = lcd_db; end
            if (lcd_db !== db_q) stab_err++;
            if (init_done) late_pulse++;
         end
         if (lcd_e && e_q && lcd_db !== db_q) stab_err++;
         if (!lcd_e && e_q) begin
            if (np < 16) fall_c[np] = ncyc;
            if (lcd_db !== db_q) stab_err++;
            np++;
         end
         if (lcd_rs !== 1'b0 || lcd_rw !== 1'b0) rsrw_err++;
         if (init_done && !done_q && done_c < 0) done_c = ncyc;
         if (init_done && np < 12) early_done++;
      end
      e_q = lcd_e; db_q = lcd_db; rst_q = rst_n; done_q = init_done;
   end

   task automatic tick();
      @(negedge clk); #2;
   endtask

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n   = 1'b0;
      mon_clr = 1;
      for (int i = 0; i < 5; i++) tick();
      // R1: reset state
      chk(lcd_e == 1'b0 && init_done == 1'b0, "R1", "e/done in reset",
          {lcd_e, init_done}, 0);
      chk(lcd_rs == 1'b0 && lcd_rw == 1'b0, "R1", "rs/rw in reset",
          {lcd_rs, lcd_rw}, 0);
      mon_clr = 0;
      rst_n   = 1'b1;
   endtask

   task automatic wait_done();
      for (int i = 0; i < 40_000 && !init_done; i++) tick();
   endtask

   function automatic logic [3:0] exp_nib(input int k);
      logic [1:0] kind;
      kind = VEC[k][21:20];
      case (kind)
         2'd1:    return {cfg_two_line, cfg_tall_font, 2'b00};
         2'd2:    return {2'b01, cfg_incr, cfg_shift};
         default: return VEC[k][19:16];
      endcase
   endfunction

   task automatic run_seq(input logic n, input logic f, input logic id, input logic s);
      cfg_two_line = n; cfg_tall_font = f; cfg_incr = id; cfg_shift = s;
      do_reset();
      wait_done();
      for (int i = 0; i < 200; i++) tick();
      chk(np == 12, "R9", "pulse count", np, 12);
      chk(rise_c[0] - rel_c > 15_000, "R1", "power-up wait", rise_c[0] - rel_c, 15_001);
      for (int k = 0; k < 12; k++) begin
         string tag;
         tag = (k < 3) ? "R2" : (k == 3) ? "R3" : "R4";
         chk(nib_c[k] == exp_nib(k), tag, $sformatf("nibble %0d", k), nib_c[k], exp_nib(k));
         chk(fall_c[k] - rise_c[k] >= 1, "R5", $sformatf("pulse %0d width", k),
             fall_c[k] - rise_c[k], 1);
         if (k < 11)
            chk(rise_c[k+1] - fall_c[k] >= longint'(VEC[k][15:0]),
                (k < 2) ? "R2" : "R6", $sformatf("gap after %0d", k),
                rise_c[k+1] - fall_c[k], VEC[k][15:0]);
      end
      chk(stab_err == 0, "R5", "data stability errors", stab_err, 0);
      chk(rsrw_err == 0, "R5", "rs/rw nonzero samples", rsrw_err, 0);
      chk(early_done == 0, "R7", "done before last pulse", early_done, 0);
      chk(init_done == 1'b1 && late_pulse == 0, "R7", "done held, no late pulse",
          {init_done, 1'b0} | (late_pulse != 0), 2);
      chk(done_c - fall_c[11] >= 50, "R7", "wait before done", done_c - fall_c[11], 50);
   endtask

   task automatic mid_reset();
      cfg_two_line = 1; cfg_tall_font = 0; cfg_incr = 1; cfg_shift = 0;
      do_reset();
      for (int i = 0; i < 40_000 && np < 5; i++) tick();
      rst_n = 1'b0;
      tick();
      // R8: reset drops outputs at once
      chk(lcd_e == 1'b0 && init_done == 1'b0, "R8", "outputs after mid reset",
          {lcd_e, init_done}, 0);
      do_reset();
      wait_done();
      chk(np == 12, "R8", "pulses after restart", np, 12);
      chk(rise_c[0] - rel_c > 15_000, "R8", "power wait after restart",
          rise_c[0] - rel_c, 15_001);
      chk(nib_c[0] == 4'h3, "R8", "first nibble after restart", nib_c[0], 3);
   endtask

   initial begin
      run_seq(1'b0, 1'b0, 1'b0, 1'b0);
      run_seq(1'b1, 1'b1, 1'b1, 1'b1);
      run_seq(1'b1, 1'b0, 1'b0, 1'b1);
      mid_reset();
      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      #(190_000 * 20);
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog R9 actual=hung expected=done");
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

endmodule